// File: doc/BRIEF.md
# Two-Channel DMA Register Block

This block holds the programming state for two DMA channels that sit behind one 32-bit register window. One channel serves a disk controller; the other serves network receive. Software programs buffer pointers into each channel and steers it through a control word. The control word is not stored as written. Each bit of a write is a command that sets or clears one status flag, and a read of the same word returns the four flags.

Each channel also has a completion input. An engine outside the block pulses it at the end of a transfer, and that pulse marks the channel complete while the channel is enabled. The block does not move data, arbitrate between bus masters or chain buffers. The network channel has only three pointer registers: next, limit and initial buffer.

Top module: `dmareg_block`

## Requirements
- R1: After reset, all four flags of both channels and every pointer register read as zero, and `rd_valid` is low.
- R2: Control-write bit 1 sets the direction flag, which reads back at bit 3. A control write with bit 1 at zero leaves the direction flag unchanged.
- R3: Control-write bit 2 sets the enable flag (read bit 0), and control-write bit 3 sets the update flag (read bit 1). Zeros in those bits change nothing.
- R4: Control-write bit 4 clears the complete flag (read bit 2) and leaves the other three flags as they were.
- R5: Control-write bit 0 clears all four flags at once. It overrides bits 1 to 3 of the same write.
- R6: A high `done_disk` or `done_net` sets that channel's complete flag when the channel's enable flag was already set before that edge. If a clear-complete command arrives in the same cycle, the done pulse wins. If a reset command arrives in the same cycle, the reset wins.
- R7: The disk channel's base offset is 0x010 and the network channel's base offset is 0x040. Relative to a channel's base, the registers sit at these offsets:
  - control at +0x0000
  - next at +0x4000
  - limit at +0x4004
  - start at +0x4008 (disk channel only)
  - stop at +0x400C (disk channel only)
  - initial buffer at +0x4200

  Each pointer register stores and returns all 32 bits, and a write to one channel never changes the other channel.
- R8: On the network channel, offsets +0x4008 and +0x400C are unmapped. They read zero, and writes to them change nothing.
- R9: An access is accepted only when `bus_size` is 4 and `bus_addr[1:0]` is 0. A write that fails this test changes nothing. A read that fails it, or a read of an unmapped offset, returns zero.
- R10: Each read request gives exactly one `rd_valid` pulse, on the cycle after the request. Its data is the register value as it stood in the request cycle. A write never raises `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte offset within the register window |
| bus_size | input | 3 | Access size in bytes; only 4 is accepted |
| bus_wdata | input | 32 | Write data or command word |
| done_disk | input | 1 | Completion pulse for the disk channel |
| done_net | input | 1 | Completion pulse for the network channel |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data, zero when `rd_valid` is low |

## Verification
A write or done pulse takes effect at the clock edge where it is sampled. Read data comes from one register stage, so it is due exactly one edge after the read request. The bench's read driver stores each expected word together with the cycle number in which it must appear. The monitor flags any read that arrives early, late, without a request, or with the wrong data.

The cases where two events meet in one cycle are driven deliberately, each followed by a readback in the next cycle:
- done together with clear-complete
- done together with reset
- done together with the write that enables the channel
- a read together with a done pulse

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

  // Control-write command bit positions
  localparam int CMD_RESET  = 0;
  localparam int CMD_DIR    = 1;
  localparam int CMD_ENABLE = 2;
  localparam int CMD_UPDATE = 3;
  localparam int CMD_CLEAR  = 4;

  // Offsets of the registers relative to a channel base
  localparam logic [31:0] OFS_CTL   = 32'h0000;
  localparam logic [31:0] OFS_NEXT  = 32'h4000;
  localparam logic [31:0] OFS_LIMIT = 32'h4004;
  localparam logic [31:0] OFS_START = 32'h4008;
  localparam logic [31:0] OFS_STOP  = 32'h400C;
  localparam logic [31:0] OFS_INIT  = 32'h4200;

  localparam int NUM_PTR = 5;

  // Pointer selects follow the control select in this order
  typedef enum logic [2:0] {
    SEL_CTL   = 3'd0,
    SEL_NEXT  = 3'd1,
    SEL_LIMIT = 3'd2,
    SEL_START = 3'd3,
    SEL_STOP  = 3'd4,
    SEL_INIT  = 3'd5,
    SEL_NONE  = 3'd7
  } reg_sel_e;

  // Read-side layout of the control word (bit 0 = enable ... bit 3 = dir)
  typedef struct packed {
    logic dir;
    logic complete;
    logic update;
    logic enable;
  } flags_t;

  function automatic reg_sel_e map_offset(input logic [31:0] ofs,
                                          input logic has_range,
                                          input logic ok);
    reg_sel_e s;
    s = SEL_NONE;
    if (ok) begin
      case (ofs)
        OFS_CTL:   s = SEL_CTL;
        OFS_NEXT:  s = SEL_NEXT;
        OFS_LIMIT: s = SEL_LIMIT;
        OFS_START: s = has_range ? SEL_START : SEL_NONE;
        OFS_STOP:  s = has_range ? SEL_STOP : SEL_NONE;
        OFS_INIT:  s = SEL_INIT;
        default:   s = SEL_NONE;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
  import dmareg_pkg::*;
#(
  parameter int               AW       = 16,
  parameter int               NCH      = 2,
  parameter int               ACC_B    = 4,
  parameter logic [NCH*AW-1:0] BASES   = '0,
  parameter logic [NCH-1:0]   RANGE_EN = '0
) (
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    size_i,
  output logic          acc_ok_o,
  output reg_sel_e      sel_o [NCH]
);

  localparam int ALIGN_W = $clog2(ACC_B);

  assign acc_ok_o = (size_i == 3'(ACC_B)) && (addr_i[ALIGN_W-1:0] == '0);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [AW-1:0] ofs;
    assign ofs      = addr_i - BASES[i*AW +: AW];
    assign sel_o[i] = map_offset(32'(ofs), RANGE_EN[i], acc_ok_o);
  end

endmodule

// File: rtl/dmareg_ptr.sv
module dmareg_ptr #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);

  logic [DW-1:0] q_d;

  always_comb begin
    q_d = q_o;
    if (we_i) q_d = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_d;
  end

  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(q_o));
  p_ptr_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (q_o == $past(d_i)));

endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan
  import dmareg_pkg::*;
#(
  parameter int DW        = 32,
  parameter bit HAS_RANGE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  reg_sel_e      sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          done_i,
  output logic [DW-1:0] rdata_o
);

  flags_t        flags_q, flags_d;
  logic          ctl_we;
  logic          rst_cmd;
  logic [DW-1:0] ptr_q [NUM_PTR];

  assign ctl_we  = wr_i && (sel_i == SEL_CTL);
  assign rst_cmd = ctl_we && wdata_i[CMD_RESET];

  // Command decode: reset first, then the set/clear commands, then done
  always_comb begin
    flags_d = flags_q;
    if (ctl_we) begin
      if (wdata_i[CMD_RESET]) begin
        flags_d = '0;
      end else begin
        if (wdata_i[CMD_DIR])    flags_d.dir      = 1'b1;
        if (wdata_i[CMD_ENABLE]) flags_d.enable   = 1'b1;
        if (wdata_i[CMD_UPDATE]) flags_d.update   = 1'b1;
        if (wdata_i[CMD_CLEAR])  flags_d.complete = 1'b0;
      end
    end
    if (done_i && flags_q.enable && !rst_cmd) flags_d.complete = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  for (genvar k = 0; k < NUM_PTR; k++) begin : g_ptr
    localparam reg_sel_e MY_SEL = reg_sel_e'(k + 1);
    if (!HAS_RANGE && (MY_SEL == SEL_START || MY_SEL == SEL_STOP)) begin : g_absent
      assign ptr_q[k] = '0;
    end else begin : g_reg
      logic we;
      assign we = wr_i && (sel_i == MY_SEL);
      dmareg_ptr #(.DW(DW)) u_ptr (
        .clk  (clk),
        .rst_n(rst_n),
        .we_i (we),
        .d_i  (wdata_i),
        .q_o  (ptr_q[k])
      );
    end
  end

  always_comb begin
    case (sel_i)
      SEL_CTL:   rdata_o = {{(DW-4){1'b0}}, flags_q};
      SEL_NEXT:  rdata_o = ptr_q[0];
      SEL_LIMIT: rdata_o = ptr_q[1];
      SEL_START: rdata_o = ptr_q[2];
      SEL_STOP:  rdata_o = ptr_q[3];
      SEL_INIT:  rdata_o = ptr_q[4];
      default:   rdata_o = '0;
    endcase
  end

  p_dir_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags_q.dir) |-> $past(rst_cmd));
  p_set_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !wdata_i[CMD_RESET] && wdata_i[CMD_ENABLE] && wdata_i[CMD_UPDATE])
      |=> (flags_q.enable && flags_q.update));
  p_clear_only_complete_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && (wdata_i[4:0] == 5'b10000))
      |=> (flags_q.enable == $past(flags_q.enable)) &&
          (flags_q.update == $past(flags_q.update)) &&
          (flags_q.dir == $past(flags_q.dir)));
  p_reset_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd |=> (flags_q == '0));
  p_done_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q.complete) |-> $past(done_i && flags_q.enable));

endmodule

// File: rtl/dmareg_block.sv
module dmareg_block
  import dmareg_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          DW        = 32,
  parameter logic [AW-1:0] DISK_BASE = 16'h0010,
  parameter logic [AW-1:0] NET_BASE  = 16'h0040
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [2:0]    bus_size,
  input  logic [DW-1:0] bus_wdata,
  input  logic          done_disk,
  input  logic          done_net,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);

  localparam int               NCH      = 2;
  localparam logic [NCH*AW-1:0] BASES   = {NET_BASE, DISK_BASE};
  localparam logic [NCH-1:0]   RANGE_EN = 2'b01;

  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic          acc_ok;
  reg_sel_e      ch_sel [NCH];
  logic [NCH-1:0] ch_done;
  logic [DW-1:0] ch_rdata [NCH];
  logic [DW-1:0] rd_mux;
  logic          rd_req;
  logic          rd_valid_d;
  logic [DW-1:0] rd_data_d;

  assign ch_done = {done_net, done_disk};
  assign rd_req  = bus_req && !bus_we;

  dmareg_decode #(
    .AW      (AW),
    .NCH     (NCH),
    .ACC_B   (4),
    .BASES   (BASES),
    .RANGE_EN(RANGE_EN)
  ) u_dec (
    .addr_i  (bus_addr),
    .size_i  (bus_size),
    .acc_ok_o(acc_ok),
    .sel_o   (ch_sel)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic wr;
    assign wr = bus_req && bus_we && (ch_sel[i] != SEL_NONE);
    dmareg_chan #(
      .DW       (DW),
      .HAS_RANGE(RANGE_EN[i])
    ) u_chan (
      .clk    (clk),
      .rst_n  (rst_i_n),
      .wr_i   (wr),
      .sel_i  (ch_sel[i]),
      .wdata_i(bus_wdata),
      .done_i (ch_done[i]),
      .rdata_o(ch_rdata[i])
    );
  end

  // Unselected channels return zero, so an OR merges them
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NCH; i++) rd_mux = rd_mux | ch_rdata[i];
  end

  always_comb begin
    rd_valid_d = rd_req;
    rd_data_d  = (rd_req && acc_ok) ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_valid_d;
      rd_data  <= rd_data_d;
    end
  end

  p_read_latency_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    rd_req |=> rd_valid);
  p_no_spurious_read_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    !rd_req |=> !rd_valid);
  p_bad_size_zero_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_req && (bus_size != 3'd4)) |=> (rd_data == '0));
  p_idle_data_zero_r1: assert property (@(posedge clk) disable iff (!rst_i_n)
    !rd_valid |-> (rd_data == '0));

endmodule

// File: tb/dmareg_block_test.sv
module dmareg_block_test;

  logic        clk;
  logic        rst_n;
  logic        bus_req;
  logic        bus_we;
  logic [15:0] bus_addr;
  logic [2:0]  bus_size;
  logic [31:0] bus_wdata;
  logic        done_disk;
  logic        done_net;
  logic        rd_valid;
  logic [31:0] rd_data;

  dmareg_block uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_size (bus_size),
    .bus_wdata(bus_wdata),
    .done_disk(done_disk),
    .done_net (done_net),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  // Command bits and read flag values
  localparam logic [31:0] C_RST = 32'h01, C_DIR = 32'h02, C_EN = 32'h04,
                          C_UPD = 32'h08, C_CLR = 32'h10;
  localparam logic [31:0] F_EN = 32'h1, F_UPD = 32'h2, F_CMP = 32'h4, F_DIR = 32'h8;
  localparam logic [15:0] D_CTL = 16'h0010, D_NEXT = 16'h4010, D_LIM = 16'h4014,
                          D_START = 16'h4018, D_STOP = 16'h401C, D_INIT = 16'h4210;
  localparam logic [15:0] N_CTL = 16'h0040, N_NEXT = 16'h4040, N_LIM = 16'h4044,
                          N_START = 16'h4048, N_STOP = 16'h404C, N_INIT = 16'h4240;

  typedef struct {
    int unsigned due;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          errors = 0;
  int unsigned cyc    = 0;
  bit          closed = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic report_and_end();
    if (!closed) begin
      closed = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Monitor: every rd_valid must match the head of the scoreboard in cycle and data
  always @(posedge clk) begin
    cyc++;
    #1;
    if (rd_valid === 1'b1) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected read data: got %h expected no read", rd_data);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (e.due != cyc || rd_data !== e.data) begin
          errors++;
          $display("FAIL %s: got %h at cycle %0d, expected %h at cycle %0d",
                   e.tag, rd_data, cyc, e.data, e.due);
        end
      end
    end else if (sb.size() != 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      errors++;
      $display("FAIL %s: got no rd_valid, expected %h at cycle %0d", e.tag, e.data, e.due);
    end
  end

  // Driver: one bus cycle, inputs change only at the falling edge
  task automatic drive(input logic we, input logic [15:0] a, input logic [2:0] sz,
                       input logic [31:0] d, input logic dd, input logic dn);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = d;
    done_disk = dd; done_net = dn;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; done_disk = 1'b0; done_net = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    drive(1'b1, a, 3'd4, d, 1'b0, 1'b0);
  endtask

  task automatic wr_done(input logic [15:0] a, input logic [31:0] d,
                         input logic dd, input logic dn);
    drive(1'b1, a, 3'd4, d, dd, dn);
  endtask

  task automatic rd_full(input logic [15:0] a, input logic [2:0] sz, input logic dd,
                         input logic dn, input logic [31:0] exp, input string tag);
    exp_t e;
    e.due = cyc + 1; e.data = exp; e.tag = tag;
    sb.push_back(e);
    drive(1'b0, a, sz, 32'h0, dd, dn);
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
    rd_full(a, 3'd4, 1'b0, 1'b0, exp, tag);
  endtask

  task automatic idle_done(input logic dd, input logic dn);
    bus_req = 1'b0; done_disk = dd; done_net = dn;
    @(negedge clk);
    done_disk = 1'b0; done_net = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got hung run, expected completion");
    report_and_end();
  end

  initial begin
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_size = 3'd4;
    bus_wdata = '0; done_disk = 1'b0; done_net = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    checks++;
    if (rd_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 rd_valid after reset: got %b expected 0", rd_valid);
    end
    rd(D_CTL, 32'h0, "R1 disk flags after reset");
    rd(D_NEXT, 32'h0, "R1 disk next after reset");
    rd(D_STOP, 32'h0, "R1 disk stop after reset");
    rd(N_CTL, 32'h0, "R1 net flags after reset");
    rd(N_INIT, 32'h0, "R1 net init after reset");

    // R2: direction set, not cleared by zero
    wr(D_CTL, C_DIR);
    rd(D_CTL, F_DIR, "R2 direction set");
    wr(D_CTL, 32'h0);
    rd(D_CTL, F_DIR, "R2 zero write keeps direction");

    // R3: enable and update
    wr(D_CTL, C_EN);
    rd(D_CTL, F_DIR | F_EN, "R3 enable set");
    wr(D_CTL, C_UPD);
    rd(D_CTL, F_DIR | F_EN | F_UPD, "R3 update set");

    // R6: done while enabled
    idle_done(1'b1, 1'b0);
    rd(D_CTL, F_DIR | F_EN | F_UPD | F_CMP, "R6 done sets complete");

    // R4: clear complete only
    wr(D_CTL, C_CLR);
    rd(D_CTL, F_DIR | F_EN | F_UPD, "R4 clear complete only");

    // R5: reset wins over set bits
    wr(D_CTL, C_RST | C_DIR | C_EN | C_UPD);
    rd(D_CTL, 32'h0, "R5 reset overrides sets");

    // R6: done ignored while disabled, and in the enabling cycle
    idle_done(1'b1, 1'b0);
    rd(D_CTL, 32'h0, "R6 done ignored when disabled");
    wr_done(D_CTL, C_EN, 1'b1, 1'b0);
    rd(D_CTL, F_EN, "R6 done in enabling cycle ignored");
    wr_done(D_CTL, C_CLR, 1'b1, 1'b0);
    rd(D_CTL, F_EN | F_CMP, "R6 done wins over clear-complete");
    wr_done(D_CTL, C_RST, 1'b1, 1'b0);
    rd(D_CTL, 32'h0, "R6 reset wins over done");

    // R7: network channel flags independent of disk
    wr(N_CTL, C_DIR | C_EN);
    rd(N_CTL, F_DIR | F_EN, "R7 net flags set");
    rd(D_CTL, 32'h0, "R7 disk flags untouched by net write");
    idle_done(1'b0, 1'b1);
    rd(N_CTL, F_DIR | F_EN | F_CMP, "R7 net done sets net complete");
    rd(D_CTL, 32'h0, "R7 net done leaves disk");

    // R7: pointers
    wr(D_NEXT, 32'h1234_5678);
    wr(D_LIM, 32'h89AB_CDEF);
    wr(D_START, 32'hA5A5_0001);
    wr(D_STOP, 32'h5A5A_0002);
    wr(D_INIT, 32'hFFFF_0003);
    wr(N_NEXT, 32'h0BAD_F00D);
    wr(N_LIM, 32'hC0DE_0004);
    wr(N_INIT, 32'h8000_0005);
    rd(D_NEXT, 32'h1234_5678, "R7 disk next");
    rd(D_LIM, 32'h89AB_CDEF, "R7 disk limit");
    rd(D_START, 32'hA5A5_0001, "R7 disk start");
    rd(D_STOP, 32'h5A5A_0002, "R7 disk stop");
    rd(D_INIT, 32'hFFFF_0003, "R7 disk init");
    rd(N_NEXT, 32'h0BAD_F00D, "R7 net next");
    rd(N_LIM, 32'hC0DE_0004, "R7 net limit");
    rd(N_INIT, 32'h8000_0005, "R7 net init");

    // R8: net start/stop absent
    wr(N_START, 32'hDEAD_BEEF);
    wr(N_STOP, 32'hDEAD_BEEF);
    rd(N_START, 32'h0, "R8 net start reads zero");
    rd(N_STOP, 32'h0, "R8 net stop reads zero");
    rd(D_START, 32'hA5A5_0001, "R8 disk start unchanged");
    rd(D_STOP, 32'h5A5A_0002, "R8 disk stop unchanged");

    // R9: size and alignment gating
    drive(1'b1, D_NEXT, 3'd2, 32'h7777_7777, 1'b0, 1'b0);
    drive(1'b1, D_NEXT + 16'd1, 3'd4, 32'h6666_6666, 1'b0, 1'b0);
    drive(1'b1, D_CTL, 3'd1, C_RST, 1'b0, 1'b0);
    rd(D_NEXT, 32'h1234_5678, "R9 narrow and unaligned writes ignored");
    rd(N_CTL, F_DIR | F_EN | F_CMP, "R9 net flags still set");
    rd_full(D_NEXT, 3'd1, 1'b0, 1'b0, 32'h0, "R9 byte read zero");
    rd_full(D_NEXT, 3'd2, 1'b0, 1'b0, 32'h0, "R9 half read zero");
    rd(D_NEXT + 16'd2, 32'h0, "R9 unaligned read zero");
    rd(16'h0100, 32'h0, "R9 unmapped read zero");

    // R10: read returns the pre-edge value when done arrives together
    wr(N_CTL, C_CLR);
    rd_full(N_CTL, 3'd4, 1'b0, 1'b1, F_DIR | F_EN, "R10 read sees value before done");
    rd(N_CTL, F_DIR | F_EN | F_CMP, "R10 done visible next read");

    repeat (4) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R10 reads outstanding: got %0d expected 0", sb.size());
    end
    report_and_end();
  end

endmodule